// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This unit synchronises a group of up to `N` participants. A participant signals its arrival with a one-cycle pulse on its bit of `arrive_i`. Its bit of `release_o` then drops and stays low until every enabled participant has arrived in the same episode. When the final arrival lands, the unit clears its arrival count and flips a global sense bit. That flip raises `release_o` for the whole group at once.

Each participant carries a private sense bit, and that bit inverts on each accepted arrival. A participant counts as released while its private bit equals the global sense. A participant that has just been released can therefore arrive again at once. That arrival opens the next episode, and no second counter is needed to keep the two episodes apart. Several arrivals in one cycle are all counted in that cycle.

The enable mask `en_i` selects the members of the group, and the release target is the number of set bits in the mask. The mask may only change while no enabled participant is waiting. An arrival from a participant that is already waiting is reported on `err_o` and is not counted.

Top module: `barrier_sense`

## Requirements
- R1: During reset and on the first cycle after it, `release_o` is all ones, `err_o` is all zeros and `sense_o` is 0.
- R2: An accepted arrival by an enabled, released participant that does not complete the episode makes its `release_o` bit 0 on the next cycle.
- R3: A waiting participant's `release_o` stays 0 until every enabled participant has arrived in the current episode, and the arrival count stays below the number of enabled participants.
- R4: On the cycle after the last enabled participant arrives, `sense_o` is inverted and `release_o` is 1 for every enabled participant, including the last arriver.
- R5: Arrivals from several enabled participants in the same cycle are all counted in that cycle.
- R6: Arrival pulses from participants whose `en_i` bit is 0 are ignored. Their `release_o` bits are 1, and the target count is the number of set bits in `en_i`.
- R7: An arrival from an enabled participant whose `release_o` is 0 sets its `err_o` bit on the next cycle and is not counted.
- R8: A participant that arrives again on the cycle right after being released waits in the new episode until all enabled participants have arrived again.
- R9: `err_o` bits are 0 in every cycle that does not follow a rejected arrival.
- R10: With `en_i` all zeros, `sense_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | N | Participant enable mask |
| arrive_i | input | N | One-cycle arrival pulses, one bit per participant |
| release_o | output | N | 1 while the participant is not waiting in the current episode |
| err_o | output | N | One-cycle flag for an arrival from a participant that is already waiting |
| sense_o | output | 1 | Global release sense; inverts when an episode completes |

## Verification
Every result is registered. The effect of an arrival pulse driven in a cycle therefore appears exactly one clock edge later: the drop of its `release_o` bit, the release of the whole group and the flip of `sense_o`, and the `err_o` flag. The bench drives each pulse at a falling edge and updates its episode model for the same edge. It compares all three outputs at the next falling edge, so every comparison sees the state produced by exactly one rising edge. The enable mask changes only at steps where the model holds no waiting participant.

// File: rtl/barrier_sense.sv
module barrier_sense #(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] arrive_i,
  output logic [N-1:0] release_o,
  output logic [N-1:0] err_o,
  output logic         sense_o
);

  function automatic logic [CW-1:0] ones(input logic [N-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int k = 0; k < N; k++) s = s + CW'(v[k]);
    return s;
  endfunction

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic [CW:0]   total;
  logic          gsense;
  logic          done;
  logic [N-1:0]  psense;
  logic [N-1:0]  waiting;
  logic [N-1:0]  take;

  assign waiting = (psense ^ {N{gsense}}) & en_i;
  assign take    = arrive_i & en_i & ~waiting;
  assign target  = ones(en_i);
  assign total   = {1'b0, cnt} + {1'b0, ones(take)};
  assign done    = (target != '0) && (total == {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      gsense <= 1'b0;
      psense <= '0;
      err_o  <= '0;
    end else begin
      err_o <= arrive_i & en_i & waiting;
      cnt   <= done ? '0 : total[CW-1:0];
      if (done) gsense <= ~gsense;
      for (int i = 0; i < N; i++) begin
        if (!en_i[i])     psense[i] <= done ? ~gsense : gsense;
        else if (take[i]) psense[i] <= ~psense[i];
      end
    end
  end

  assign release_o = ~(psense ^ {N{gsense}});
  assign sense_o   = gsense;

endmodule

// File: rtl/barrier_sense_chk.sv
module barrier_sense_chk #(
  parameter int N = 8,
  localparam int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  en_i,
  input logic [N-1:0]  arrive_i,
  input logic [N-1:0]  release_o,
  input logic [N-1:0]  err_o,
  input logic          sense_o,
  input logic [CW-1:0] cnt
);

  p_count_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i != '0) |-> (int'(cnt) < $countones(en_i)));

  p_group_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_o != $past(sense_o)) |-> ((release_o | ~$past(en_i)) == '1));

  p_idle_sense_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> $stable(sense_o));

  for (genvar i = 0; i < N; i++) begin : g_bit
    p_arrive_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arrive_i[i] && en_i[i] && release_o[i]) |=> (!release_o[i] || (sense_o != $past(sense_o))));

    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (arrive_i[i] && en_i[i] && !release_o[i]) |=> err_o[i]);

    p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(arrive_i[i] && en_i[i] && !release_o[i]) |=> !err_o[i]);
  end

endmodule

bind barrier_sense barrier_sense_chk #(.N(N)) u_chk (.*);

// File: tb/barrier_sense_tb.sv
module barrier_sense_tb;
  localparam int N = 4;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] en_i;
  logic [N-1:0] arrive_i;
  logic [N-1:0] release_o;
  logic [N-1:0] err_o;
  logic         sense_o;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_arr;
  logic         m_g;
  logic [N-1:0] m_err;

  barrier_sense #(.N(N)) u_dut (.*);

  always #(CLK_P / 2) clk = ~clk;

  task automatic cmp(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_err(input logic [N-1:0] a, input logic [N-1:0] e, input logic [N-1:0] arr);
    return a & e & arr;
  endfunction

  task automatic step(input logic [N-1:0] a, input string tag);
    logic [N-1:0] tk;
    arrive_i = a;
    m_err = exp_err(a, en_i, m_arr);
    tk = a & en_i & ~m_arr;
    m_arr = m_arr | tk;
    if (en_i != '0 && (m_arr & en_i) == en_i) begin
      m_arr = '0;
      m_g = ~m_g;
    end
    @(negedge clk);
    arrive_i = '0;
    cmp(tag, "release", release_o, ~m_arr);
    cmp(tag, "err", err_o, m_err);
    cmp(tag, "sense", {{(N-1){1'b0}}, sense_o}, {{(N-1){1'b0}}, m_g});
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    en_i = '1;
    arrive_i = '0;
    m_arr = '0;
    m_g = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1", "release", release_o, '1);
    cmp("R1", "err", err_o, '0);
    cmp("R1", "sense", {{(N-1){1'b0}}, sense_o}, '0);
    rst_n = 1'b1;
    step('0, "R1");

    step(4'b0001, "R2");
    step(4'b0001, "R7");
    step(4'b0110, "R5");
    step(4'b1000, "R4");
    step(4'b1000, "R8");
    step(4'b0000, "R8");
    step(4'b0011, "R8");
    step(4'b0100, "R8");

    en_i = 4'b0101;
    step(4'b1010, "R6");
    step(4'b0001, "R6");
    step(4'b0100, "R6");

    en_i = '0;
    step(4'b1111, "R10");
    step(4'b0011, "R10");

    en_i = '1;
    step(4'b1111, "R5");

    for (int n = 0; n < 4000; n++) begin
      if (m_arr == '0 && ($urandom % 8) == 0) begin
        en_i = N'($urandom);
      end
      step(N'($urandom) & N'($urandom), "R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule